// File: doc/BRIEF.md
# I2C Batch Transaction Sequencer

This block drives a buffered I2C master engine whose data buffer holds only a few bytes. A host hands it one request: a read or a write, a 7-bit target address, a byte count, and a flag that keeps the bus session open after the request ends. The sequencer splits the request into chunks that fit the engine buffer. The address byte takes one buffer slot, and only in the first chunk. For each chunk it sets the engine's start, stop and final-read attributes. It copies outgoing bytes from a host stream into the buffer, or copies fetched bytes from the buffer out to a host stream. It then triggers the engine and waits for the result.

Each chunk has its own wait limit, which grows with the chunk's byte count and shrinks as the bus speed rises. The first chunk that fails, or that runs past its limit, ends the request. Completion is shown by a one-cycle pulse that carries a status code. While a request is running, a new request is not accepted.

Top module: `i2c_batch_seq`

## Requirements
- R1: A request whose operation code is not 2'b01 (read) or 2'b10 (write) ends with status 5 (invalid operation) and triggers no chunk. This check comes before the length check.
- R2: A valid operation with a byte count of zero ends with status 3 (incomplete) and triggers no chunk.
- R3: Let B be the buffer depth and n the bytes still to move. The first chunk carries p = min(n, B-1) data bytes and reports size p+1. Every later chunk carries and reports min(n, B). The request therefore uses 1 + ceil(max(len-(B-1),0)/B) chunks.
- R4: The start attribute is 1 on the first chunk and 0 on every later chunk.
- R5: The stop attribute is 1 only on the final chunk, and only when the session-hold flag was 0 at request time.
- R6: The final-read attribute is 1 on the final chunk and 0 on every earlier chunk.
- R7: Before the first chunk is triggered, buffer slot 0 holds {address[6:0], read} (read = 1 for a read). For writes, host bytes fill the buffer in stream order before each trigger: slots 1.. in the first chunk, slots 0.. in later chunks.
- R8: For reads, after each successful chunk the bytes are streamed out in order, one per cycle with rd_valid high. They are taken from slot 1 onward in the first chunk and from slot 0 onward in later chunks.
- R9: The wait limit is L = (1000*K/speed)*(8*size+2) cycles, using integer division, with L = 0 when speed is 0. Wait cycle 0 is the first cycle after the trigger. A result presented in wait cycle L or earlier is accepted. Otherwise the request ends with status 2 (timeout).
- R10: The first chunk whose result code is not 0 ends the request. Result 1 gives status 1 (no acknowledge), 2 gives 2, 3 gives 3, and 4 to 7 give 4 (operation failure). Data from a failed read chunk is not streamed.
- R11: After reset, and between requests, req_ready is 1. A request completes with exactly one cycle of done, with the final status valid in that cycle; status 0 means success. req_ready stays 0 from the cycle after acceptance until done, so requests presented during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and accepting a request |
| req_op | input | 2 | 01 read, 10 write, other codes invalid |
| req_addr | input | 7 | Target address |
| req_len | input | LEN_W | Byte count |
| req_hold | input | 1 | Keep session open (no stop) after the request |
| bus_speed | input | SPD_W | Bus speed used in the wait limit |
| wr_valid | input | 1 | Outgoing byte available |
| wr_ready | output | 1 | Sequencer takes an outgoing byte |
| wr_data | input | 8 | Outgoing byte |
| rd_valid | output | 1 | Fetched byte present |
| rd_data | output | 8 | Fetched byte |
| eng_buf_we | output | 1 | Engine buffer write strobe |
| eng_buf_addr | output | IDX_W | Engine buffer slot |
| eng_buf_wdata | output | 8 | Engine buffer write byte |
| eng_buf_rdata | input | 8 | Engine buffer byte at eng_buf_addr |
| eng_go | output | 1 | One-cycle chunk trigger |
| eng_start | output | 1 | Start attribute of the chunk |
| eng_stop | output | 1 | Stop attribute of the chunk |
| eng_last_read | output | 1 | Final-read attribute of the chunk |
| eng_size | output | CNT_W | Chunk size including any address slot |
| eng_done | input | 1 | Engine result present |
| eng_res | input | 3 | Engine result code |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Final status code |

## Verification
The bench builds the block with a buffer depth of 4 and K = 1. With this depth, lengths 0 to 13 run through every split from zero to four chunks, including the lengths where the last chunk exactly fills the buffer. A bus speed of 1000 makes the wait limit 8*size+2 cycles, short enough for the bench to drive a result exactly at the limit and one cycle past it. Speeds of 0, 500 and 3000 exercise the zero and truncated cases of the formula.

// File: rtl/i2c_batch_pkg.sv
package i2c_batch_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_OK         = 3'd0,
    ST_NACK       = 3'd1,
    ST_TIMEOUT    = 3'd2,
    ST_INCOMPLETE = 3'd3,
    ST_OPFAIL     = 3'd4,
    ST_BADOP      = 3'd5
  } status_e;

  localparam logic [2:0] RES_OK     = 3'd0;
  localparam logic [2:0] RES_NORESP = 3'd1;
  localparam logic [2:0] RES_TMO    = 3'd2;
  localparam logic [2:0] RES_FAIL   = 3'd3;

  // engine result code to final request status
  function automatic status_e map_result(input logic [2:0] r);
    case (r)
      RES_OK:     return ST_OK;
      RES_NORESP: return ST_NACK;
      RES_TMO:    return ST_TIMEOUT;
      RES_FAIL:   return ST_INCOMPLETE;
      default:    return ST_OPFAIL;
    endcase
  endfunction

  // data bytes carried by the next chunk; the first one loses a slot to the address
  function automatic int unsigned chunk_payload(input int unsigned rem,
                                                input bit first,
                                                input int unsigned depth);
    int unsigned room;
    room = first ? depth - 1 : depth;
    return (rem > room) ? room : rem;
  endfunction

  // cycles allowed for one chunk: per-bit period times (data bits + start + stop)
  function automatic logic [31:0] wait_limit(input int unsigned k,
                                             input int unsigned speed,
                                             input int unsigned tsize);
    if (speed == 0) return '0;
    return ((1000 * k) / speed) * (8 * tsize + 2);
  endfunction

endpackage

// File: rtl/i2c_chunk_plan.sv
module i2c_chunk_plan
  import i2c_batch_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LEN_W = 8,
  parameter int CNT_W = 4
) (
  input  logic [LEN_W-1:0] remaining,
  input  logic             first,
  output logic [CNT_W-1:0] xfer_size,
  output logic [CNT_W-1:0] payload_size,
  output logic             last_chunk
);

  int unsigned pay;

  always_comb begin
    pay          = chunk_payload(32'(remaining), first, DEPTH);
    payload_size = CNT_W'(pay);
    xfer_size    = first ? CNT_W'(pay + 1) : CNT_W'(pay);
    last_chunk   = (32'(remaining) == pay);
  end

endmodule

// File: rtl/i2c_wait_timer.sv
module i2c_wait_timer
  import i2c_batch_pkg::*;
#(
  parameter int TMO_K = 1,
  parameter int SPD_W = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             run,
  input  logic [SPD_W-1:0] speed,
  input  logic [CNT_W-1:0] xfer_size,
  output logic             expired
);

  logic [31:0] limit_q;
  logic [31:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
      cnt_q   <= '0;
    end else if (arm) begin
      limit_q <= wait_limit(TMO_K, 32'(speed), 32'(xfer_size));
      cnt_q   <= '0;
    end else if (run && cnt_q != '1) begin
      cnt_q <= cnt_q + 32'd1;
    end
  end

  assign expired = run && (cnt_q >= limit_q);

endmodule

// File: rtl/i2c_batch_seq.sv
module i2c_batch_seq
  import i2c_batch_pkg::*;
#(
  parameter  int DEPTH = 8,
  parameter  int LEN_W = 8,
  parameter  int SPD_W = 16,
  parameter  int TMO_K = 1,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [6:0]       req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_hold,
  input  logic [SPD_W-1:0] bus_speed,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             eng_buf_we,
  output logic [IDX_W-1:0] eng_buf_addr,
  output logic [7:0]       eng_buf_wdata,
  input  logic [7:0]       eng_buf_rdata,
  output logic             eng_go,
  output logic             eng_start,
  output logic             eng_stop,
  output logic             eng_last_read,
  output logic [CNT_W-1:0] eng_size,
  input  logic             eng_done,
  input  logic [2:0]       eng_res,
  output logic             done,
  output logic [2:0]       status
);

  typedef enum logic [3:0] {
    S_IDLE, S_PLAN, S_ADDR, S_LOAD, S_FIRE, S_WAIT, S_UNLOAD, S_ADV, S_DONE
  } state_e;

  state_e           state_q;
  logic             rd_q, hold_q, first_q, last_q;
  logic [6:0]       addr_q;
  logic [LEN_W-1:0] rem_q;
  logic [CNT_W-1:0] xfer_q, pay_q, bcnt_q;
  logic [IDX_W-1:0] idx_q;
  status_e          status_q;

  // named internal events used by the checker
  logic             chunk_first;
  logic             in_wait;
  logic             wait_expired;
  logic             op_ok;
  logic             byte_step;
  logic             chunk_filled;

  logic [CNT_W-1:0] plan_xfer, plan_pay;
  logic             plan_last;

  assign chunk_first  = first_q;
  assign in_wait      = (state_q == S_WAIT);
  assign op_ok        = (req_op == OP_READ) || (req_op == OP_WRITE);
  assign byte_step    = (state_q == S_UNLOAD) || (state_q == S_LOAD && wr_valid);
  assign chunk_filled = (bcnt_q + CNT_W'(1) == pay_q);

  i2c_chunk_plan #(
    .DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) plan_i (
    .remaining   (rem_q),
    .first       (first_q),
    .xfer_size   (plan_xfer),
    .payload_size(plan_pay),
    .last_chunk  (plan_last)
  );

  i2c_wait_timer #(
    .TMO_K(TMO_K), .SPD_W(SPD_W), .CNT_W(CNT_W)
  ) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (eng_go),
    .run      (in_wait),
    .speed    (bus_speed),
    .xfer_size(xfer_q),
    .expired  (wait_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      rd_q     <= 1'b0;
      hold_q   <= 1'b0;
      first_q  <= 1'b0;
      last_q   <= 1'b0;
      addr_q   <= '0;
      rem_q    <= '0;
      xfer_q   <= '0;
      pay_q    <= '0;
      bcnt_q   <= '0;
      idx_q    <= '0;
      status_q <= ST_OK;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            if (!op_ok) begin
              status_q <= ST_BADOP;
              state_q  <= S_DONE;
            end else if (req_len == '0) begin
              status_q <= ST_INCOMPLETE;
              state_q  <= S_DONE;
            end else begin
              rd_q    <= (req_op == OP_READ);
              addr_q  <= req_addr;
              hold_q  <= req_hold;
              rem_q   <= req_len;
              first_q <= 1'b1;
              state_q <= S_PLAN;
            end
          end
        end
        S_PLAN: begin
          xfer_q  <= plan_xfer;
          pay_q   <= plan_pay;
          last_q  <= plan_last;
          idx_q   <= first_q ? IDX_W'(1) : '0;
          bcnt_q  <= '0;
          if (first_q)   state_q <= S_ADDR;
          else if (rd_q) state_q <= S_FIRE;
          else           state_q <= S_LOAD;
        end
        S_ADDR: begin
          state_q <= rd_q ? S_FIRE : S_LOAD;
        end
        S_LOAD: begin
          if (byte_step) begin
            idx_q  <= idx_q + IDX_W'(1);
            bcnt_q <= bcnt_q + CNT_W'(1);
            if (chunk_filled) state_q <= S_FIRE;
          end
        end
        S_FIRE: begin
          idx_q   <= first_q ? IDX_W'(1) : '0;
          bcnt_q  <= '0;
          state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (eng_done) begin
            if (eng_res == RES_OK) begin
              state_q <= rd_q ? S_UNLOAD : S_ADV;
            end else begin
              status_q <= map_result(eng_res);
              state_q  <= S_DONE;
            end
          end else if (wait_expired) begin
            status_q <= ST_TIMEOUT;
            state_q  <= S_DONE;
          end
        end
        S_UNLOAD: begin
          idx_q  <= idx_q + IDX_W'(1);
          bcnt_q <= bcnt_q + CNT_W'(1);
          if (chunk_filled) state_q <= S_ADV;
        end
        S_ADV: begin
          rem_q   <= rem_q - LEN_W'(pay_q);
          first_q <= 1'b0;
          if (last_q) begin
            status_q <= ST_OK;
            state_q  <= S_DONE;
          end else begin
            state_q <= S_PLAN;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    eng_buf_we    = 1'b0;
    eng_buf_addr  = idx_q;
    eng_buf_wdata = wr_data;
    if (state_q == S_ADDR) begin
      eng_buf_we    = 1'b1;
      eng_buf_addr  = '0;
      eng_buf_wdata = {addr_q, rd_q};
    end else if (state_q == S_LOAD) begin
      eng_buf_we = wr_valid;
    end
  end

  assign req_ready     = (state_q == S_IDLE);
  assign wr_ready      = (state_q == S_LOAD);
  assign rd_valid      = (state_q == S_UNLOAD);
  assign rd_data       = eng_buf_rdata;
  assign eng_go        = (state_q == S_FIRE);
  assign eng_start     = first_q;
  assign eng_stop      = last_q && !hold_q;
  assign eng_last_read = last_q;
  assign eng_size      = xfer_q;
  assign done          = (state_q == S_DONE);
  assign status        = status_q;

endmodule

// File: rtl/i2c_batch_seq_chk.sv
module i2c_batch_seq_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             eng_go,
  input logic             eng_start,
  input logic             eng_stop,
  input logic             eng_last_read,
  input logic [CNT_W-1:0] eng_size,
  input logic             eng_buf_we,
  input logic             rd_valid,
  input logic             eng_done,
  input logic [2:0]       eng_res,
  input logic             done,
  input logic [2:0]       status,
  input logic             in_wait,
  input logic             wait_expired
);

  a_r3_size_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |-> (eng_size != '0 && 32'(eng_size) <= DEPTH));

  a_r4_first_has_address_slot: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go && eng_start |-> eng_size >= CNT_W'(2));

  a_r5_stop_only_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go && eng_stop |-> eng_last_read);

  a_r7_no_load_after_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |=> !eng_buf_we);

  a_r8_buffer_ports_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_go, eng_buf_we, rd_valid}));

  a_r9_expiry_reports_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    wait_expired && !eng_done |=> done && status == 3'd2);

  a_r10_failure_ends_request: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait && eng_done && eng_res != 3'd0 |=> done && status != 3'd0);

  a_r11_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

endmodule

bind i2c_batch_seq i2c_batch_seq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .eng_go       (eng_go),
  .eng_start    (eng_start),
  .eng_stop     (eng_stop),
  .eng_last_read(eng_last_read),
  .eng_size     (eng_size),
  .eng_buf_we   (eng_buf_we),
  .rd_valid     (rd_valid),
  .eng_done     (eng_done),
  .eng_res      (eng_res),
  .done         (done),
  .status       (status),
  .in_wait      (in_wait),
  .wait_expired (wait_expired)
);

// File: tb/i2c_batch_seq_tb_top.sv
module i2c_batch_seq_tb_top;
  localparam int DEPTH = 4;
  localparam int LEN_W = 8;
  localparam int SPD_W = 16;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic             req_valid = 1'b0, req_ready, req_hold = 1'b0;
  logic [1:0]       req_op = 2'b00;
  logic [6:0]       req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [SPD_W-1:0] bus_speed = 16'd1000;
  logic             wr_valid = 1'b0, wr_ready;
  logic [7:0]       wr_data = '0;
  logic             rd_valid;
  logic [7:0]       rd_data;
  logic             eng_buf_we;
  logic [IDX_W-1:0] eng_buf_addr;
  logic [7:0]       eng_buf_wdata, eng_buf_rdata;
  logic             eng_go, eng_start, eng_stop, eng_last_read;
  logic [CNT_W-1:0] eng_size;
  logic             eng_done = 1'b0;
  logic [2:0]       eng_res = 3'd0;
  logic             done;
  logic [2:0]       status;

  i2c_batch_seq #(.DEPTH(DEPTH), .LEN_W(LEN_W), .SPD_W(SPD_W), .TMO_K(1)) dut_i (.*);

  int vec = 0, bad = 0, cyc = 0;
  int seed = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 29 + seed + 11) & 255);
  endfunction

  // engine buffer model
  logic [7:0] wbuf [0:DEPTH-1];
  logic [7:0] rbuf [0:DEPTH-1];
  always @(posedge clk) if (eng_buf_we) wbuf[eng_buf_addr] <= eng_buf_wdata;
  assign eng_buf_rdata = rbuf[eng_buf_addr];

  // expected chunk progression and engine responder
  int e_rem, e_first, e_hold, e_read, e_addr, e_wb, e_rb, nchunk;
  int fail_chunk = -1, fail_code = 0, tmo_chunk = -1, tmo_delay = 1;
  int pend = 0, pcnt = 0, pdelay = 1, pcode = 0;

  task automatic model_chunk();
    int room, p, t, lst;
    room = e_first ? DEPTH - 1 : DEPTH;
    p    = (e_rem < room) ? e_rem : room;
    t    = p + e_first;
    lst  = (p == e_rem);
    chk(int'(eng_size) == t, "R3 chunk size", eng_size, t);
    chk(eng_start == 1'(e_first), "R4 start attribute", eng_start, e_first);
    chk(eng_stop == 1'(lst && !e_hold), "R5 stop attribute", eng_stop, lst && !e_hold);
    chk(eng_last_read == 1'(lst), "R6 final-read attribute", eng_last_read, lst);
    if (e_first != 0)
      chk(wbuf[0] == {e_addr[6:0], e_read[0]}, "R7 address slot", wbuf[0], {e_addr[6:0], e_read[0]});
    if (e_read == 0) begin
      for (int i = 0; i < p; i++)
        chk(wbuf[i + e_first] == pat(e_wb + i), "R7 write byte", wbuf[i + e_first], pat(e_wb + i));
      e_wb += p;
    end else begin
      for (int i = 0; i < p; i++) rbuf[i + e_first] = pat(e_rb + i);
      e_rb += p;
    end
    pcode  = (nchunk == fail_chunk) ? fail_code : 0;
    pdelay = (nchunk == tmo_chunk) ? tmo_delay : 1;
    pend   = 1;
    pcnt   = 0;
    e_rem -= p;
    e_first = 0;
    nchunk++;
  endtask

  always @(negedge clk) begin
    eng_done = 1'b0;
    if (pend != 0) begin
      pcnt++;
      if (pcnt >= pdelay) begin
        eng_done = 1'b1;
        eng_res  = 3'(pcode);
        pend     = 0;
      end
    end
    if (done) pend = 0;
    if (eng_go) model_chunk();
  end

  // read stream monitor
  int rd_seen = 0;
  always @(negedge clk) if (rd_valid) begin
    chk(rd_data == pat(rd_seen), "R8 read byte order", rd_data, pat(rd_seen));
    rd_seen++;
  end

  // write stream source
  int wr_idx = 0;
  bit wr_take = 0, stall = 0;
  always @(negedge clk) begin
    if (wr_take) wr_idx++;
    wr_valid = stall ? ((cyc % 3) != 0) : 1'b1;
    wr_data  = pat(wr_idx);
    wr_take  = wr_valid && wr_ready;
  end

  int ndone = 0;
  always @(negedge clk) if (done) ndone++;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  task automatic run(input int op, input int len, input int hold, input int spd,
                     input int exp_st, input int exp_ch, input bit busy, input string tag);
    int t;
    @(negedge clk);
    seed = len * 7 + op * 3 + hold * 5;
    e_rem = len; e_first = 1; e_hold = hold; e_read = (op == 1) ? 1 : 0;
    e_addr = (len * 13 + op * 5 + 7) & 127;
    e_wb = 0; e_rb = 0; nchunk = 0; rd_seen = 0; wr_idx = 0; wr_take = 0;
    ndone = 0; pend = 0;
    bus_speed = SPD_W'(spd);
    req_op = 2'(op); req_addr = 7'(e_addr); req_len = LEN_W'(len); req_hold = 1'(hold);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    if (busy) req_op = 2'b11;
    else req_valid = 1'b0;
    t = 0;
    while (!done && t < 4000) begin @(negedge clk); t++; end
    chk(done, "R11 completion pulse", done, 1);
    req_valid = 1'b0;
    chk(int'(status) == exp_st, tag, status, exp_st);
    chk(nchunk == exp_ch, "R3 chunk count", nchunk, exp_ch);
    if (exp_st == 0 && op == 1) chk(rd_seen == len, "R8 bytes streamed", rd_seen, len);
    if (exp_st == 0 && op == 2) chk(wr_idx == len, "R7 bytes consumed", wr_idx, len);
    @(negedge clk);
    chk(!done, "R11 done lasts one cycle", done, 0);
    chk(ndone == 1, "R11 single completion", ndone, 1);
    chk(req_ready, "R11 ready when idle", req_ready, 1);
  endtask

  function automatic int chunks_for(input int len);
    if (len == 0) return 0;
    if (len <= DEPTH - 1) return 1;
    return 1 + (len - (DEPTH - 1) + DEPTH - 1) / DEPTH;
  endfunction

  function automatic int lim(input int spd, input int t);
    if (spd == 0) return 0;
    return (1000 / spd) * (8 * t + 2);
  endfunction

  function automatic int st_of(input int c);
    return (c <= 3) ? c : 4;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R11 reset ready", req_ready, 1);
    chk(!done, "R11 reset done low", done, 0);
    chk(!eng_go && !rd_valid && !wr_ready, "R11 reset outputs idle", eng_go, 0);

    // sweep of lengths, directions and session hold (R2 at length 0)
    for (int op = 1; op <= 2; op++)
      for (int hold = 0; hold <= 1; hold++)
        for (int len = 0; len <= 13; len++) begin
          stall = (len % 2) == 1;
          run(op, len, hold, 1000, (len == 0) ? 3 : 0, chunks_for(len), 1'b0,
              (len == 0) ? "R2 zero length status" : "R3 sweep status");
        end
    stall = 0;

    // R1 invalid operations, checked before the length
    run(0, 5, 0, 1000, 5, 0, 1'b0, "R1 invalid op 00");
    run(3, 5, 0, 1000, 5, 0, 1'b0, "R1 invalid op 11");
    run(3, 0, 0, 1000, 5, 0, 1'b0, "R1 invalid op zero length");

    // R10 result mapping on a middle write chunk
    for (int c = 1; c <= 7; c++) begin
      fail_chunk = 1; fail_code = c;
      run(2, 9, 0, 1000, st_of(c), 2, 1'b0, "R10 result mapping");
    end
    fail_chunk = 0; fail_code = 3;
    run(1, 9, 0, 1000, 3, 1, 1'b0, "R10 first read chunk fails");
    chk(rd_seen == 0, "R10 no bytes from failed chunk", rd_seen, 0);
    fail_chunk = 2; fail_code = 1;
    run(1, 9, 1, 1000, 1, 3, 1'b0, "R10 last read chunk fails");
    chk(rd_seen == 7, "R10 partial read", rd_seen, 7);
    fail_chunk = -1; fail_code = 0;

    // R9 wait limit boundaries; first chunk of length 2 has size 3
    tmo_chunk = 0;
    tmo_delay = lim(1000, 3) + 1; run(2, 2, 0, 1000, 0, 1, 1'b0, "R9 result at limit accepted");
    tmo_delay = lim(1000, 3) + 2; run(2, 2, 0, 1000, 2, 1, 1'b0, "R9 result past limit");
    tmo_delay = 1;                run(2, 2, 0, 0,    0, 1, 1'b0, "R9 zero speed at cycle 0");
    tmo_delay = 2;                run(2, 2, 0, 0,    2, 1, 1'b0, "R9 zero speed timeout");
    tmo_delay = lim(500, 3) + 1;  run(1, 2, 0, 500,  0, 1, 1'b0, "R9 slow bus at limit");
    tmo_delay = lim(500, 3) + 2;  run(1, 2, 0, 500,  2, 1, 1'b0, "R9 slow bus past limit");
    tmo_delay = 2;                run(2, 2, 0, 3000, 2, 1, 1'b0, "R9 truncated period");
    tmo_chunk = 1;
    tmo_delay = lim(1000, 4) + 2; run(2, 9, 0, 1000, 2, 2, 1'b0, "R9 later chunk timeout");
    tmo_delay = lim(1000, 4) + 1; run(2, 9, 0, 1000, 0, 3, 1'b0, "R9 later chunk at limit");
    tmo_chunk = -1; tmo_delay = 1;

    // R11 requests held during a transfer are ignored
    run(2, 9, 0, 1000, 0, 3, 1'b1, "R11 busy request ignored");

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule